// File: doc/BRIEF.md
# Two-Beat Word Packer for a Double-Rate Memory Port

This block sits between a narrow data port that moves two data beats per cycle and an internal storage array whose word is twice the port width. On a write it collects the two beats, places each into one half of a wide word and commits both halves to the array in one operation. On a read it fetches one wide word in a single array access and sends its halves back as two beats, with beat 0 first in time. The double-rate port is modelled on one single-rate clock, with both beats presented together in one cycle.

The write is a late write. The command and address come in one cycle, and the beats and their lane enables come in the next cycle. Reads have a fixed latency of one cycle. A read issued while a write is still waiting for its data is ordered after the commit of the write data present in that cycle, with merging done lane by lane. A parameter selects the beat ordering. In address order, address bit 0 names the half that travels as beat 0, which gives critical-word-first transfers. In fixed order, bit 0 is ignored and the lower half always goes first.

Top module: `beat_pair_ram`

## Requirements
- R1: While reset is held, and with no read issued after it, `rd_valid` is 0.
- R2: `rd_valid` is 1 in exactly the cycle after a cycle in which `rd_en` was 1, and is 0 otherwise.
- R3: A write command in cycle t takes its beats and lane enables from cycle t+1. A read issued in cycle t+2 or later returns both halves written by that single commit.
- R4: In address order, a write with address bit 0 = 0 puts beat 0 into the lower half (bits DW-1:0) and beat 1 into the upper half. With bit 0 = 1 it puts beat 0 into the upper half and beat 1 into the lower half.
- R5: In address order, a read with address bit 0 = s returns half s on `rd_beat0` and the other half on `rd_beat1`. Half 0 is the lower half. Row = address bits above bit 0.
- R6: Lane l of a beat covers bits 9l+8 down to 9l. Only the lanes whose enable bit is 1 are updated, and disabled lanes keep their previous content.
- R7: A read of a row, issued in the cycle that carries the data of an earlier write to the same row, returns the merged word: newly enabled lanes new, all other lanes old.
- R8: A read issued in the same cycle as a write command to the same row returns the content from before that write.
- R9: In fixed order, address bit 0 has no effect on reads or writes. Beat 0 always maps to the lower half and beat 1 to the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write command |
| wr_addr | input | ADDR_W (9) | Write address: row in upper bits, starting half in bit 0 |
| wr_beat0 | input | DW (18) | First write beat, sampled the cycle after the command |
| wr_beat1 | input | DW (18) | Second write beat, sampled the cycle after the command |
| wr_lanes0 | input | LANES (2) | Lane enables for beat 0 |
| wr_lanes1 | input | LANES (2) | Lane enables for beat 1 |
| rd_en | input | 1 | Read command |
| rd_addr | input | ADDR_W (9) | Read address: row in upper bits, starting half in bit 0 |
| rd_valid | output | 1 | Read beats valid |
| rd_beat0 | output | DW (18) | First read beat |
| rd_beat1 | output | DW (18) | Second read beat |

## Verification
The bench builds the block twice with the default sizes: 18-bit beats, two 9-bit lanes and 256 rows. One instance runs in address order and one in fixed order, and both receive identical stimulus. At this size every row can be written with alternating start halves and then read back with both values of bit 0, so every row and both beat orders are covered. All four lane-enable combinations per beat are covered as well. Back-to-back command sequences on one row bring the same-cycle ordering and the data-cycle merge into reach, including two writes to one row in a row.

// File: rtl/beat_pair_pkg.sv
package beat_pair_pkg;

  // Beat ordering policy for two-beat transfers.
  typedef enum logic {
    ORDER_ADDR  = 1'b0,  // address bit 0 picks the half sent first
    ORDER_FIXED = 1'b1   // lower half always first, bit 0 ignored
  } order_mode_e;

endpackage

// File: rtl/bp_write_gather.sv
module bp_write_gather
  import beat_pair_pkg::*;
#(
  parameter int          DW     = 18,
  parameter int          LANE_W = 9,
  parameter int          ROW_W  = 8,
  parameter order_mode_e MODE   = ORDER_ADDR,
  localparam int         LANES  = DW / LANE_W,
  localparam int         WW     = 2 * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W:0]   wr_addr,
  input  logic [DW-1:0]    wr_beat0,
  input  logic [DW-1:0]    wr_beat1,
  input  logic [LANES-1:0] wr_lanes0,
  input  logic [LANES-1:0] wr_lanes1,
  output logic             commit_en,
  output logic [ROW_W-1:0] commit_row,
  output logic [WW-1:0]    commit_word,
  output logic [WW-1:0]    commit_mask
);

  logic             cmd_first;
  logic             pend_vld_q, pend_vld_d;
  logic [ROW_W-1:0] pend_row_q, pend_row_d;
  logic             pend_first_q, pend_first_d;
  logic [DW-1:0]    lo_beat, hi_beat;
  logic [LANES-1:0] lo_lanes, hi_lanes;

  generate
    if (MODE == ORDER_FIXED) begin : g_fixed_ptr
      assign cmd_first = 1'b0;
    end else begin : g_addr_ptr
      assign cmd_first = wr_addr[0];
    end
  endgenerate

  always_comb begin
    pend_vld_d   = wr_en;
    pend_row_d   = pend_row_q;
    pend_first_d = pend_first_q;
    if (wr_en) begin
      pend_row_d   = wr_addr[ROW_W:1];
      pend_first_d = cmd_first;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q   <= 1'b0;
      pend_row_q   <= '0;
      pend_first_q <= 1'b0;
    end else begin
      pend_vld_q   <= pend_vld_d;
      pend_row_q   <= pend_row_d;
      pend_first_q <= pend_first_d;
    end
  end

  // Demux: steer each beat into its half from the latched pointer.
  assign lo_beat  = pend_first_q ? wr_beat1  : wr_beat0;
  assign hi_beat  = pend_first_q ? wr_beat0  : wr_beat1;
  assign lo_lanes = pend_first_q ? wr_lanes1 : wr_lanes0;
  assign hi_lanes = pend_first_q ? wr_lanes0 : wr_lanes1;

  assign commit_en   = pend_vld_q;
  assign commit_row  = pend_row_q;
  assign commit_word = {hi_beat, lo_beat};

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane_mask
      assign commit_mask[l*LANE_W +: LANE_W]      = {LANE_W{lo_lanes[l]}};
      assign commit_mask[DW + l*LANE_W +: LANE_W] = {LANE_W{hi_lanes[l]}};
    end
  endgenerate

  AST_LATE_DATA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> commit_en);  // R3
  AST_NO_PHANTOM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !commit_en);  // R3

endmodule

// File: rtl/bp_word_array.sv
module bp_word_array #(
  parameter int  WW    = 36,
  parameter int  ROW_W = 8,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [WW-1:0]    wr_word,
  input  logic [WW-1:0]    wr_mask,
  input  logic [ROW_W-1:0] rd_row,
  output logic [WW-1:0]    rd_word
);

  logic [WW-1:0] mem [DEPTH];
  logic [WW-1:0] old_row;
  logic [WW-1:0] new_row;

  assign old_row = mem[wr_row];
  assign new_row = (old_row & ~wr_mask) | (wr_word & wr_mask);
  assign rd_word = mem[rd_row];

  // Storage carries no reset; write is clock-enabled by the commit.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_row] <= new_row;
    end
  end

  AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((mem[$past(wr_row)] ^ $past(old_row)) & ~$past(wr_mask)) == '0));  // R6
  AST_LANE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((mem[$past(wr_row)] ^ $past(wr_word)) & $past(wr_mask)) == '0));  // R6

endmodule

// File: rtl/bp_read_steer.sv
module bp_read_steer
  import beat_pair_pkg::*;
#(
  parameter int          DW    = 18,
  parameter int          ROW_W = 8,
  parameter order_mode_e MODE  = ORDER_ADDR,
  localparam int         WW    = 2 * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [ROW_W:0]   rd_addr,
  output logic [ROW_W-1:0] rd_row,
  input  logic [WW-1:0]    arr_word,
  input  logic             commit_en,
  input  logic [ROW_W-1:0] commit_row,
  input  logic [WW-1:0]    commit_word,
  input  logic [WW-1:0]    commit_mask,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_beat0,
  output logic [DW-1:0]    rd_beat1
);

  logic          rd_first;
  logic          fwd_hit;
  logic [WW-1:0] fresh_word;
  logic [DW-1:0] steer0, steer1;
  logic          valid_q, valid_d;
  logic [DW-1:0] beat0_q, beat0_d, beat1_q, beat1_d;

  generate
    if (MODE == ORDER_FIXED) begin : g_fixed_ptr
      assign rd_first = 1'b0;
    end else begin : g_addr_ptr
      assign rd_first = rd_addr[0];
    end
  endgenerate

  assign rd_row = rd_addr[ROW_W:1];

  // Coherence: fold in the write whose data is on the port this cycle.
  assign fwd_hit    = commit_en && (commit_row == rd_row);
  assign fresh_word = fwd_hit ? ((arr_word & ~commit_mask) | (commit_word & commit_mask))
                              : arr_word;

  // Mux: pick the half that travels first.
  assign steer0 = rd_first ? fresh_word[WW-1:DW] : fresh_word[DW-1:0];
  assign steer1 = rd_first ? fresh_word[DW-1:0]  : fresh_word[WW-1:DW];

  always_comb begin
    valid_d = rd_en;
    beat0_d = beat0_q;
    beat1_d = beat1_q;
    if (rd_en) begin
      beat0_d = steer0;
      beat1_d = steer1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat0_q <= '0;
      beat1_q <= '0;
    end else begin
      valid_q <= valid_d;
      beat0_q <= beat0_d;
      beat1_q <= beat1_d;
    end
  end

  assign rd_valid = valid_q;
  assign rd_beat0 = beat0_q;
  assign rd_beat1 = beat1_q;

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);  // R2
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);  // R2
  AST_RD_BOTH_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (({rd_beat1, rd_beat0} == $past(fresh_word)) ||
               ({rd_beat0, rd_beat1} == $past(fresh_word))));  // R5

endmodule

// File: rtl/beat_pair_ram.sv
module beat_pair_ram
  import beat_pair_pkg::*;
#(
  parameter int          DW     = 18,
  parameter int          LANE_W = 9,
  parameter int          DEPTH  = 256,
  parameter order_mode_e MODE   = ORDER_ADDR,
  localparam int         LANES  = DW / LANE_W,
  localparam int         ROW_W  = $clog2(DEPTH),
  localparam int         ADDR_W = ROW_W + 1,
  localparam int         WW     = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_beat0,
  input  logic [DW-1:0]     wr_beat1,
  input  logic [LANES-1:0]  wr_lanes0,
  input  logic [LANES-1:0]  wr_lanes1,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_beat0,
  output logic [DW-1:0]     rd_beat1
);

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             commit_en;
  logic [ROW_W-1:0] commit_row;
  logic [WW-1:0]    commit_word;
  logic [WW-1:0]    commit_mask;
  logic [ROW_W-1:0] rd_row;
  logic [WW-1:0]    arr_word;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  bp_write_gather #(
    .DW(DW), .LANE_W(LANE_W), .ROW_W(ROW_W), .MODE(MODE)
  ) u_gather (
    .clk(clk), .rst_n(core_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_beat0(wr_beat0), .wr_beat1(wr_beat1),
    .wr_lanes0(wr_lanes0), .wr_lanes1(wr_lanes1),
    .commit_en(commit_en), .commit_row(commit_row),
    .commit_word(commit_word), .commit_mask(commit_mask)
  );

  bp_word_array #(
    .WW(WW), .ROW_W(ROW_W)
  ) u_array (
    .clk(clk), .rst_n(core_rst_n),
    .wr_en(commit_en), .wr_row(commit_row),
    .wr_word(commit_word), .wr_mask(commit_mask),
    .rd_row(rd_row), .rd_word(arr_word)
  );

  bp_read_steer #(
    .DW(DW), .ROW_W(ROW_W), .MODE(MODE)
  ) u_steer (
    .clk(clk), .rst_n(core_rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_row(rd_row),
    .arr_word(arr_word),
    .commit_en(commit_en), .commit_row(commit_row),
    .commit_word(commit_word), .commit_mask(commit_mask),
    .rd_valid(rd_valid), .rd_beat0(rd_beat0), .rd_beat1(rd_beat1)
  );

endmodule

// File: tb/beat_pair_ram_tb_top.sv
`timescale 1ns/1ps
module beat_pair_ram_tb_top;
  import beat_pair_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [8:0]  wr_addr, rd_addr;
  logic [17:0] wr_beat0, wr_beat1;
  logic [1:0]  wr_lanes0, wr_lanes1;
  logic        av, fv;
  logic [17:0] ab0, ab1, fb0, fb1;

  int n_chk;
  int n_fail;

  logic [35:0] ref_a [256];
  logic [35:0] ref_f [256];
  logic        pv;
  logic [8:0]  paddr;

  beat_pair_ram #(.MODE(ORDER_ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_beat0(wr_beat0), .wr_beat1(wr_beat1),
    .wr_lanes0(wr_lanes0), .wr_lanes1(wr_lanes1),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(av), .rd_beat0(ab0), .rd_beat1(ab1)
  );

  beat_pair_ram #(.MODE(ORDER_FIXED)) dut_fx_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_beat0(wr_beat0), .wr_beat1(wr_beat1),
    .wr_lanes0(wr_lanes0), .wr_lanes1(wr_lanes1),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(fv), .rd_beat0(fb0), .rd_beat1(fb1)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [17:0] pat(int row, int b, int pass);
    return 18'((row * 613 + b * 2909 + pass * 7919) ^ 'h2A5A5);
  endfunction

  // Merge two beats into a wide word; first = half that beat 0 lands in.
  function automatic logic [35:0] merge_w(logic [35:0] old, logic first,
                                          logic [17:0] b0, logic [17:0] b1,
                                          logic [1:0] l0, logic [1:0] l1);
    logic [35:0] w;
    logic [17:0] bt;
    logic [1:0]  ln;
    w = old;
    for (int b = 0; b < 2; b++) begin
      bt = (b == 0) ? b0 : b1;
      ln = (b == 0) ? l0 : l1;
      for (int l = 0; l < 2; l++) begin
        if (ln[l]) w[((b ^ int'(first)) * 18) + l * 9 +: 9] = bt[l * 9 +: 9];
      end
    end
    return w;
  endfunction

  // Returns {beat0, beat1}.
  function automatic logic [35:0] steer(logic [35:0] w, logic first);
    return first ? {w[35:18], w[17:0]} : {w[17:0], w[35:18]};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check outputs at the following negedge.
  task automatic cycle(logic we, logic [8:0] wa, logic [17:0] d0, logic [17:0] d1,
                       logic [1:0] l0, logic [1:0] l1, logic re, logic [8:0] ra,
                       string tag);
    logic [35:0] exp_a, exp_f;
    wr_en = we; wr_addr = wa; wr_beat0 = d0; wr_beat1 = d1;
    wr_lanes0 = l0; wr_lanes1 = l1; rd_en = re; rd_addr = ra;
    if (pv) begin
      ref_a[paddr[8:1]] = merge_w(ref_a[paddr[8:1]], paddr[0], d0, d1, l0, l1);
      ref_f[paddr[8:1]] = merge_w(ref_f[paddr[8:1]], 1'b0, d0, d1, l0, l1);
    end
    exp_a = steer(ref_a[ra[8:1]], ra[0]);
    exp_f = steer(ref_f[ra[8:1]], 1'b0);
    pv = we;
    paddr = wa;
    @(negedge clk);
    check("R2 valid addr-order", 64'(av), 64'(re));
    check("R2 valid fixed-order", 64'(fv), 64'(re));
    if (re) begin
      check(tag, 64'({ab0, ab1}), 64'(exp_a));
      check("R9 fixed-order data", 64'({fb0, fb1}), 64'(exp_f));
    end
  endtask

  task automatic idle(string tag);
    cycle(1'b0, '0, '0, '0, '0, '0, 1'b0, '0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; pv = 1'b0; paddr = '0;
    rst_n = 1'b0;
    wr_en = 0; rd_en = 0; wr_addr = '0; rd_addr = '0;
    wr_beat0 = '0; wr_beat1 = '0; wr_lanes0 = '0; wr_lanes1 = '0;
    for (int r = 0; r < 256; r++) begin ref_a[r] = '0; ref_f[r] = '0; end

    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      check("R1 valid in reset", 64'({av, fv}), 64'(0));
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 valid after reset", 64'({av, fv}), 64'(0));
    end

    // R4: fill every row, start half alternating with the row
    for (int i = 0; i <= 256; i++) begin
      logic [7:0] wr_row_i;
      wr_row_i = 8'(i);
      cycle(i < 256, {wr_row_i, wr_row_i[0]},
            pat(i - 1, 0, 0), pat(i - 1, 1, 0), 2'b11, 2'b11,
            1'b0, '0, "R4");
    end

    // R5: read every row with both start halves (R4 data order checked too)
    for (int r = 0; r < 256; r++) begin
      for (int s = 0; s < 2; s++) begin
        cycle(1'b0, '0, '0, '0, '0, '0, 1'b1, {8'(r), 1'(s)}, "R5 read order");
      end
    end

    // R6: every lane-enable combination, both start halves
    for (int r = 0; r < 32; r++) begin
      logic [7:0] row8;
      row8 = 8'(r * 7 + 3);
      cycle(1'b1, {row8, row8[3]}, '0, '0, '0, '0, 1'b0, '0, "R6");
      cycle(1'b0, '0, pat(r, 0, 1), pat(r, 1, 1), 2'(r % 4), 2'(r / 4),
            1'b0, '0, "R6");
      cycle(1'b0, '0, '0, '0, '0, '0, 1'b1, {row8, 1'b0}, "R6 lane update");
      cycle(1'b0, '0, '0, '0, '0, '0, 1'b1, {row8, 1'b1}, "R6 lane update");
    end

    // R7, R8, R3: coherence on back-to-back commands to one row
    for (int r = 0; r < 16; r++) begin
      logic [7:0] row8;
      row8 = 8'(40 + r * 5);
      cycle(1'b1, {row8, 1'(r)}, '0, '0, '0, '0,
            1'b1, {row8, 1'(r >> 1)}, "R8 same-cycle command");
      cycle(1'b1, {row8, 1'(~r)}, pat(r, 0, 2), pat(r, 1, 2), 2'(r % 4), 2'(3 - r % 4),
            1'b1, {row8, 1'(r >> 2)}, "R7 merge in data cycle");
      cycle(1'b0, '0, pat(r, 0, 3), pat(r, 1, 3), 2'((r + 1) % 4), 2'(r % 3),
            1'b1, {row8, 1'(r)}, "R7 merge second write");
      cycle(1'b0, '0, '0, '0, '0, '0, 1'b1, {row8, 1'(~r)}, "R3 committed word");
      idle("R2");
    end

    // R9: fixed order with full-lane writes and bit 0 flipped on read
    for (int r = 0; r < 8; r++) begin
      logic [7:0] row8;
      row8 = 8'(200 + r);
      cycle(1'b1, {row8, 1'b1}, '0, '0, '0, '0, 1'b0, '0, "R9");
      cycle(1'b0, '0, pat(r, 0, 4), pat(r, 1, 4), 2'b11, 2'b11, 1'b0, '0, "R9");
      cycle(1'b0, '0, '0, '0, '0, '0, 1'b1, {row8, 1'b0}, "R4 start half one");
      n_chk++;
      if ({fb0, fb1} !== {pat(r, 0, 4), pat(r, 1, 4)}) begin
        n_fail++;
        $display("FAIL R9 bit0 ignored act=%h exp=%h", {fb0, fb1},
                 {pat(r, 0, 4), pat(r, 1, 4)});
      end
    end

    idle("R2");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule